// File: doc/BRIEF.md
# Five-Source Prioritised Interrupt Controller

This block chooses which of five interrupt requests a small 8-bit processor core services next. The sources are a non-maskable trap, three restart requests with fixed vectors (named by their levels 7.5, 6.5 and 5.5), and a general request. The general request has no fixed vector. When it wins, the block raises an acknowledge strobe. The core then holds its program counter and takes a restart or call instruction from the data bus.

The core marks each instruction boundary with a one-cycle strobe. Arbitration happens only on that strobe. The result appears one clock later as a one-cycle take pulse, a source code and a vector address. The core can set or clear the enable flag with one-cycle commands. It can also write the three restart mask bits, and the same write can discard a latched 7.5 edge. A status byte is always driven with the mask bits, the enable flag and the pending bits, so the core can read it at any time.

Top module: `intCtl`

## Requirements
- R1: An asserted trap request wins arbitration whatever the enable flag, the mask or the other requests. It gives source code 1 and vector 0x24, and the enable flag is left unchanged.
- R2: Among the maskable sources the priority is 7.5, then 6.5, then 5.5, then the general request.
- R3: A maskable source is accepted only while the enable flag is 1. A restart source is also skipped while its mask bit is 1. The general request ignores the mask bits.
- R4: A rising edge on the 7.5 input sets a pending latch, and this happens even while the source is masked or disabled. The latch is cleared when 7.5 is accepted or when a mask write has its clear flag set; a clear in the same cycle as an edge wins. Holding the input high does not set the latch again.
- R5: The enable flag is set by the enable command and cleared by the disable command. Accepting any maskable source also clears it, and that clear overrides an enable command given in the same cycle.
- R6: When the general request is accepted, intAck is 1 for exactly the one cycle of the take pulse, with source code 5 and vector 0x00.
- R7: Source codes and vectors are: 7.5 gives code 2 and vector 0x3C; 6.5 gives code 3 and vector 0x34; 5.5 gives code 4 and vector 0x2C.
- R8: Arbitration happens only in a cycle with instBoundary high. The result is registered at that clock edge. In every cycle without a take, takeValid, takeSrc, vectorAddr and intAck are all 0.
- R9: The status byte is laid out as follows. Bits [2:0] are the mask (bit 2 for 7.5, bit 1 for 6.5, bit 0 for 5.5). Bit 3 is the enable flag. Bit 4 is the 5.5 input, bit 5 is the 6.5 input and bit 6 is the 7.5 latch. Bit 7 is 0.
- R10: After reset the enable flag is 0, the mask is 111, the 7.5 latch is clear and no take is signalled, so the status reads 0x07.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instBoundary | input | 1 | Core is at an instruction boundary; arbitrate now |
| trapReq | input | 1 | Non-maskable trap request, level |
| rst75Req | input | 1 | Restart 7.5 request, rising-edge latched |
| rst65Req | input | 1 | Restart 6.5 request, level |
| rst55Req | input | 1 | Restart 5.5 request, level |
| genReq | input | 1 | General request, level, serviced through the data bus |
| eiCmd | input | 1 | Set the enable flag |
| diCmd | input | 1 | Clear the enable flag |
| maskWr | input | 1 | Write the mask bits |
| maskWrData | input | 3 | New mask, bit 2 for 7.5, bit 1 for 6.5, bit 0 for 5.5 |
| maskClr75 | input | 1 | With maskWr, clear the 7.5 latch |
| takeValid | output | 1 | One-cycle pulse: an interrupt was accepted |
| takeSrc | output | 3 | Accepted source code, 0 when there is no take |
| vectorAddr | output | 8 | Vector of the accepted source |
| intAck | output | 1 | General request acknowledged; fetch the instruction from the bus |
| status | output | 8 | Mask, enable flag and pending bits |

## Verification
The assertions take for granted that the core never gives the enable and disable commands in the same cycle. They also assume a trap request is held only as long as the core needs it, because a level trap is taken again at every boundary it stays high. The stimulus drives each command and each boundary as a single-cycle pulse on the falling edge. It releases the trap and the level requests right after the take that serviced them, and it never overlaps the enable and disable commands.

// File: rtl/intCtlPkg.sv
package intCtlPkg;
  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_TRAP = 3'd1,
    SRC_R75  = 3'd2,
    SRC_R65  = 3'd3,
    SRC_R55  = 3'd4,
    SRC_GEN  = 3'd5
  } srcT;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;
    srcT  src;
    logic clrIe;
    logic setIe;
    logic clrPend75;
    logic wrMask;
  } strobeT;

  localparam int RESTART_N = 3;
endpackage

// File: rtl/intCtlCtrl.sv
module intCtlCtrl
  import intCtlPkg::*;
(
  input  logic                 instBoundary,
  input  logic                 trapReq,
  input  logic                 rst65Req,
  input  logic                 rst55Req,
  input  logic                 genReq,
  input  logic                 eiCmd,
  input  logic                 diCmd,
  input  logic                 maskWr,
  input  logic                 maskClr75,
  input  logic                 ie,
  input  logic [RESTART_N-1:0] mask,
  input  logic                 pend75,
  output strobeT               stb
);
  srcT win;

  // fixed priority: trap, then enabled restarts high to low, then general
  always_comb begin
    win = SRC_NONE;
    if (trapReq)                      win = SRC_TRAP;
    else if (ie) begin
      if (pend75 && !mask[2])         win = SRC_R75;
      else if (rst65Req && !mask[1])  win = SRC_R65;
      else if (rst55Req && !mask[0])  win = SRC_R55;
      else if (genReq)                win = SRC_GEN;
    end
  end

  always_comb begin
    stb.accept    = instBoundary && (win != SRC_NONE);
    stb.src       = stb.accept ? win : SRC_NONE;
    stb.clrIe     = (stb.accept && (win != SRC_TRAP)) || diCmd;
    stb.setIe     = eiCmd;
    stb.clrPend75 = (stb.accept && (win == SRC_R75)) || (maskWr && maskClr75);
    stb.wrMask    = maskWr;
  end
endmodule

// File: rtl/intCtlDp.sv
module intCtlDp
  import intCtlPkg::*;
#(
  parameter int         VEC_W    = 8,
  parameter logic [7:0] VEC_TRAP = 8'h24,
  parameter logic [7:0] VEC_R75  = 8'h3C,
  parameter logic [7:0] VEC_R65  = 8'h34,
  parameter logic [7:0] VEC_R55  = 8'h2C
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobeT               stb,
  input  logic                 rst75Req,
  input  logic                 rst65Req,
  input  logic                 rst55Req,
  input  logic [RESTART_N-1:0] maskWrData,
  output logic                 ie,
  output logic [RESTART_N-1:0] mask,
  output logic                 pend75,
  output logic                 takeValid,
  output logic [2:0]           takeSrc,
  output logic [VEC_W-1:0]     vectorAddr,
  output logic                 intAck,
  output logic [7:0]           status
);
  logic prev75;
  logic edge75;
  logic [VEC_W-1:0] vecSel;

  assign edge75 = rst75Req && !prev75;

  always_comb begin
    unique case (stb.src)
      SRC_TRAP: vecSel = VEC_W'(VEC_TRAP);
      SRC_R75:  vecSel = VEC_W'(VEC_R75);
      SRC_R65:  vecSel = VEC_W'(VEC_R65);
      SRC_R55:  vecSel = VEC_W'(VEC_R55);
      default:  vecSel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ie         <= 1'b0;
      mask       <= '1;
      pend75     <= 1'b0;
      prev75     <= 1'b0;
      takeValid  <= 1'b0;
      takeSrc    <= '0;
      vectorAddr <= '0;
      intAck     <= 1'b0;
    end else begin
      prev75 <= rst75Req;
      if (stb.clrPend75)  pend75 <= 1'b0;
      else if (edge75)    pend75 <= 1'b1;
      if (stb.clrIe)      ie <= 1'b0;
      else if (stb.setIe) ie <= 1'b1;
      if (stb.wrMask)     mask <= maskWrData;
      takeValid  <= stb.accept;
      takeSrc    <= stb.src;
      vectorAddr <= vecSel;
      intAck     <= stb.src == SRC_GEN;
    end
  end

  assign status = {1'b0, pend75, rst65Req, rst55Req, ie, mask};
endmodule

// File: rtl/intCtl.sv
module intCtl
  import intCtlPkg::*;
#(
  parameter int VEC_W = 8
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             instBoundary,
  input  logic             trapReq,
  input  logic             rst75Req,
  input  logic             rst65Req,
  input  logic             rst55Req,
  input  logic             genReq,
  input  logic             eiCmd,
  input  logic             diCmd,
  input  logic             maskWr,
  input  logic [2:0]       maskWrData,
  input  logic             maskClr75,
  output logic             takeValid,
  output logic [2:0]       takeSrc,
  output logic [VEC_W-1:0] vectorAddr,
  output logic             intAck,
  output logic [7:0]       status
);
  strobeT                 stb;
  logic                   ie;
  logic                   pend75;
  logic [RESTART_N-1:0]   mask;

  intCtlCtrl u_ctrl (
    .instBoundary(instBoundary), .trapReq(trapReq), .rst65Req(rst65Req),
    .rst55Req(rst55Req), .genReq(genReq), .eiCmd(eiCmd), .diCmd(diCmd),
    .maskWr(maskWr), .maskClr75(maskClr75), .ie(ie), .mask(mask),
    .pend75(pend75), .stb(stb)
  );

  intCtlDp #(.VEC_W(VEC_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rst75Req(rst75Req),
    .rst65Req(rst65Req), .rst55Req(rst55Req), .maskWrData(maskWrData),
    .ie(ie), .mask(mask), .pend75(pend75), .takeValid(takeValid),
    .takeSrc(takeSrc), .vectorAddr(vectorAddr), .intAck(intAck),
    .status(status)
  );
endmodule

// File: rtl/intCtlChk.sv
module intCtlChk #(
  parameter int VEC_W = 8
)(
  input logic             clk,
  input logic             rstN,
  input logic             instBoundary,
  input logic             trapReq,
  input logic             eiCmd,
  input logic             diCmd,
  input logic             takeValid,
  input logic [2:0]       takeSrc,
  input logic [VEC_W-1:0] vectorAddr,
  input logic             intAck,
  input logic [7:0]       status
);
  a_r1_trap_wins: assert property (@(posedge clk) disable iff (!rstN)
    instBoundary && trapReq |=> takeValid && takeSrc == 3'd1 && vectorAddr == VEC_W'(8'h24));

  a_r3_disabled_no_take: assert property (@(posedge clk) disable iff (!rstN)
    instBoundary && !trapReq && !status[3] |=> !takeValid);

  a_r5_take_clears_ie: assert property (@(posedge clk) disable iff (!rstN)
    takeValid && takeSrc != 3'd1 |-> !status[3]);

  a_r5_ei_sets: assert property (@(posedge clk) disable iff (!rstN)
    eiCmd && !diCmd && !instBoundary |=> status[3]);

  a_r6_ack_only_general: assert property (@(posedge clk) disable iff (!rstN)
    intAck |-> takeValid && takeSrc == 3'd5 && vectorAddr == '0);

  a_r6_ack_single: assert property (@(posedge clk) disable iff (!rstN)
    intAck |=> !intAck);

  a_r7_vec75: assert property (@(posedge clk) disable iff (!rstN)
    takeValid && takeSrc == 3'd2 |-> vectorAddr == VEC_W'(8'h3C));

  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !takeValid |-> takeSrc == 3'd0 && vectorAddr == '0 && !intAck);

  a_r8_boundary_only: assert property (@(posedge clk) disable iff (!rstN)
    !instBoundary |=> !takeValid);
endmodule

bind intCtl intCtlChk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rstN(rstN), .instBoundary(instBoundary), .trapReq(trapReq),
  .eiCmd(eiCmd), .diCmd(diCmd), .takeValid(takeValid), .takeSrc(takeSrc),
  .vectorAddr(vectorAddr), .intAck(intAck), .status(status)
);

// File: tb/intCtl_tb.sv
module intCtl_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instBoundary = 0, trapReq = 0, rst75Req = 0, rst65Req = 0, rst55Req = 0;
  logic genReq = 0, eiCmd = 0, diCmd = 0, maskWr = 0, maskClr75 = 0;
  logic [2:0] maskWrData = '0;
  logic       takeValid, intAck;
  logic [2:0] takeSrc;
  logic [7:0] vectorAddr, status;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  intCtl u_dut (
    .clk(clk), .rstN(rstN), .instBoundary(instBoundary), .trapReq(trapReq),
    .rst75Req(rst75Req), .rst65Req(rst65Req), .rst55Req(rst55Req),
    .genReq(genReq), .eiCmd(eiCmd), .diCmd(diCmd), .maskWr(maskWr),
    .maskWrData(maskWrData), .maskClr75(maskClr75), .takeValid(takeValid),
    .takeSrc(takeSrc), .vectorAddr(vectorAddr), .intAck(intAck), .status(status)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic boundary();
    instBoundary = 1; tick(); instBoundary = 0;
  endtask

  task automatic chkTake(input string req, input logic [2:0] src, input logic [7:0] vec);
    chk(req, {7'd0, takeValid}, 8'd1);
    chk(req, {5'd0, takeSrc}, {5'd0, src});
    chk(req, vectorAddr, vec);
  endtask

  task automatic chkNoTake(input string req);
    chk(req, {4'd0, takeValid, takeSrc}, 8'd0);
    chk(req, vectorAddr, 8'd0);
    chk(req, {7'd0, intAck}, 8'd0);
  endtask

  task automatic enable();
    eiCmd = 1; tick(); eiCmd = 0;
  endtask

  task automatic writeMask(input logic [2:0] m, input logic clr);
    maskWr = 1; maskWrData = m; maskClr75 = clr; tick();
    maskWr = 0; maskClr75 = 0;
  endtask

  task automatic tReset();
    chk("R10 status", status, 8'h07);
    chkNoTake("R10 outputs");
  endtask

  task automatic tTrap();
    trapReq = 1; boundary(); trapReq = 0;
    chkTake("R1 trap disabled", 3'd1, 8'h24);
    chk("R1 ie unchanged", {7'd0, status[3]}, 8'd0);
    tick();
    chkNoTake("R8 pulse ends");
    boundary();
    chkNoTake("R8 no request");
  endtask

  task automatic tEnableMask();
    enable();
    chk("R5 ei", {7'd0, status[3]}, 8'd1);
    diCmd = 1; tick(); diCmd = 0;
    chk("R5 di", {7'd0, status[3]}, 8'd0);
    writeMask(3'b000, 1'b0);
    chk("R9 mask write", status, 8'h00);
  endtask

  task automatic tPriority();
    rst75Req = 1; tick(); rst75Req = 0;
    chk("R4 latched while disabled", status, 8'h40);
    boundary();
    chkNoTake("R3 disabled");
    rst65Req = 1; rst55Req = 1; genReq = 1;
    enable();
    eiCmd = 1; boundary(); eiCmd = 0;
    chkTake("R2 R7 7.5 first", 3'd2, 8'h3C);
    chk("R5 R4 after take", status, 8'h30);
    enable(); boundary();
    chkTake("R2 R7 6.5 next", 3'd3, 8'h34);
    rst65Req = 0; enable(); boundary();
    chkTake("R2 R7 5.5 next", 3'd4, 8'h2C);
    rst55Req = 0; enable(); boundary();
    chkTake("R6 general", 3'd5, 8'h00);
    chk("R6 ack", {7'd0, intAck}, 8'd1);
    tick();
    chk("R6 ack one cycle", {7'd0, intAck}, 8'd0);
  endtask

  task automatic tMask();
    writeMask(3'b111, 1'b0);
    rst65Req = 1; enable(); boundary();
    chkTake("R3 masked 6.5 general ignores mask", 3'd5, 8'h00);
    rst65Req = 0; genReq = 0;
    writeMask(3'b000, 1'b0);
    rst75Req = 1; tick();
    chk("R4 edge latched", {7'd0, status[6]}, 8'd1);
    writeMask(3'b000, 1'b1);
    chk("R4 mask write clears latch", {7'd0, status[6]}, 8'd0);
    tick();
    chk("R4 held high no relatch", {7'd0, status[6]}, 8'd0);
    enable(); boundary();
    chkNoTake("R4 cleared latch not taken");
    rst75Req = 0; tick(); rst75Req = 1; tick();
    boundary();
    chkTake("R4 new edge taken", 3'd2, 8'h3C);
    enable(); boundary();
    chkNoTake("R4 held level not retaken");
    rst75Req = 0;
  endtask

  task automatic tBoundaryOnly();
    genReq = 1; tick(); tick();
    chkNoTake("R8 no boundary");
    eiCmd = 1; boundary(); eiCmd = 0; genReq = 0;
    chkTake("R8 take on boundary", 3'd5, 8'h00);
    chk("R5 accept beats ei", {7'd0, status[3]}, 8'd0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); tick(); tick();
    rstN = 1; tick();
    tReset();
    tTrap();
    tEnableMask();
    tPriority();
    tMask();
    tBoundaryOnly();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule